// File: doc/BRIEF.md
# Two-bit branch history table

This block predicts the direction of conditional branches in the fetch stage of a pipelined processor. It holds a direct-mapped table of small per-entry predictors. The table has no tags, so any two branches whose word addresses agree in the index bits share one entry. On every cycle the lookup side takes the fetch PC and returns a taken or not-taken guess combinationally, in the same cycle. Later in the pipeline the branch resolves. The update side then receives that branch's PC and its real outcome and adjusts the entry it selects.

A parameter picks one of two entry kinds. The first is a 2-bit saturating counter with hysteresis, so a strongly biased branch needs two wrong guesses in a row before its prediction turns. The second is a 1-bit entry that simply remembers the last outcome. The difference shows clearly on loop-closing branches. The 2-bit kind mispredicts once per loop exit. The 1-bit kind mispredicts twice: once on the exit and once on the first iteration of the next pass.

Top module: `branch_dir_table`

## Requirements
- R1: After reset every entry predicts not taken. In 2-bit mode each entry starts at state 01 (weakly not taken), so a single taken update makes that entry predict taken. In 1-bit mode each entry starts at 0, and a single taken update also makes it predict taken.
- R2: The entry is selected by PC bits [IDX_BITS+1:2]. Bits [1:0] and every bit above the index are ignored, so PCs that differ only in those bits share one entry. A PC whose index differs is unaffected by updates to that entry.
- R3: In 2-bit mode the entry state goes up by one on a taken update and down by one on a not-taken update. The prediction is taken when the state is 10 or 11.
- R4: In 2-bit mode, starting from a strong state (11 or 00), one wrong outcome leaves the prediction unchanged. A second consecutive wrong outcome flips it.
- R5: In 2-bit mode the state stays at 11 on another taken update and stays at 00 on another not-taken update.
- R6: In 1-bit mode the entry holds the most recent resolved outcome. It is therefore inverted exactly when its prediction was wrong.
- R7: When a lookup and an update select the same entry in one cycle, the lookup returns the value from before the update. The new value is visible from the next cycle.
- R8: When up_en is low, no entry changes, whatever up_pc and up_taken hold.
- R9: For a branch at a fresh entry that follows repeated passes of nine taken outcomes and then one not taken, every pass after the first gives one misprediction in 2-bit mode and two in 1-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of all entries |
| lk_pc | input | PC_W | PC being fetched |
| lk_taken | output | 1 | Prediction for lk_pc: 1 = taken |
| up_en | input | 1 | An update is presented this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch: 1 = taken |

## Verification
The bound checker watches the state transitions on every cycle in which the lookup PC equals the update PC and stays put for the next cycle. It checks saturating increment and decrement in 2-bit mode, last-outcome tracking in 1-bit mode, that the output holds when no update is presented, and the reset value. Aliasing through the ignored PC bits, the two-misses-to-flip hysteresis across separate cycles, and the per-pass loop misprediction counts only appear in the bench's directed scenarios. The bench compares both modes against a behavioural model on every clock.

// File: rtl/branch_dir_table.sv
module branch_dir_table #(
  parameter int PC_W     = 32,
  parameter int IDX_BITS = 12,
  parameter bit TWO_BIT  = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            up_en,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);
  localparam int DEPTH = 1 << IDX_BITS;
  localparam int ENT_W = TWO_BIT ? 2 : 1;
  localparam logic [ENT_W-1:0] RST_VAL = ENT_W'(TWO_BIT);

  logic [ENT_W-1:0] tbl [DEPTH];
  logic [ENT_W-1:0] lk_cur, up_cur, up_nxt;
  logic [1:0]       lk_state;

  wire [IDX_BITS-1:0] lk_idx = lk_pc[IDX_BITS+1:2];
  wire [IDX_BITS-1:0] up_idx = up_pc[IDX_BITS+1:2];

  assign lk_cur   = tbl[lk_idx];
  assign up_cur   = tbl[up_idx];
  assign lk_taken = lk_cur[ENT_W-1];

  generate
    if (TWO_BIT) begin : g_ctr
      always_comb begin
        if (up_taken) up_nxt = (up_cur == 2'b11) ? up_cur : up_cur + 2'b01;
        else          up_nxt = (up_cur == 2'b00) ? up_cur : up_cur - 2'b01;
      end
      assign lk_state = lk_cur;
    end else begin : g_bit
      assign up_nxt   = up_taken;
      assign lk_state = {1'b0, lk_cur};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= RST_VAL;
    end else if (up_en) begin
      tbl[up_idx] <= up_nxt;
    end
  end

  wire unused_ok = ^{lk_pc[PC_W-1:IDX_BITS+2], lk_pc[1:0],
                     up_pc[PC_W-1:IDX_BITS+2], up_pc[1:0], lk_state};
endmodule

module branch_dir_table_chk #(
  parameter int PC_W    = 32,
  parameter bit TWO_BIT = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] lk_pc,
  input logic            lk_taken,
  input logic            up_en,
  input logic [PC_W-1:0] up_pc,
  input logic            up_taken,
  input logic [1:0]      lk_state
);
  // R1
  reset_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !lk_taken);

  // R8
  no_update_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_en |=> (!$stable(lk_pc) || $stable(lk_taken)));

  generate
    if (TWO_BIT) begin : g_two
      // R3
      inc_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && up_taken && lk_pc == up_pc) |=>
        (!$stable(lk_pc) ||
         lk_state == (($past(lk_state) == 2'b11) ? 2'b11 : $past(lk_state) + 2'b01)));
      // R5
      dec_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && !up_taken && lk_pc == up_pc) |=>
        (!$stable(lk_pc) ||
         lk_state == (($past(lk_state) == 2'b00) ? 2'b00 : $past(lk_state) - 2'b01)));
    end else begin : g_one
      // R6
      last_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && lk_pc == up_pc) |=>
        (!$stable(lk_pc) || lk_taken == $past(up_taken)));
    end
  endgenerate
endmodule

bind branch_dir_table branch_dir_table_chk #(.PC_W(PC_W), .TWO_BIT(TWO_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
  .up_en(up_en), .up_pc(up_pc), .up_taken(up_taken), .lk_state(lk_state));

// File: tb/sim_branch_dir_table.sv
module sim_branch_dir_table;
  localparam int CLK_NS = 10;
  localparam int IDXB   = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] lk_pc = '0, up_pc = '0;
  logic up_en = 1'b0, up_taken = 1'b0;
  logic lk0, lk1;
  int errors = 0, checks = 0;
  int m2 [int];
  bit m1 [int];
  logic p0, p1;

  always #(CLK_NS/2) clk = ~clk;

  branch_dir_table #(.IDX_BITS(IDXB), .TWO_BIT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk0),
    .up_en(up_en), .up_pc(up_pc), .up_taken(up_taken));
  branch_dir_table #(.IDX_BITS(IDXB), .TWO_BIT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk1),
    .up_en(up_en), .up_pc(up_pc), .up_taken(up_taken));

  function automatic int ix(logic [31:0] pc);
    return int'((pc >> 2) % (32'd1 << IDXB));
  endfunction
  function automatic int get2(int i);
    return m2.exists(i) ? m2[i] : 1;
  endfunction
  function automatic bit get1(int i);
    return m1.exists(i) ? m1[i] : 1'b0;
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic [31:0] lpc, logic ue, logic [31:0] upc, logic ut);
    int u;
    @(negedge clk);
    lk_pc = lpc; up_en = ue; up_pc = upc; up_taken = ut;
    #1;
    chk(tag, "2-bit prediction", lk0, get2(ix(lpc)) >= 2);
    chk(tag, "1-bit prediction", lk1, get1(ix(lpc)));
    p0 = lk0; p1 = lk1;
    if (ue) begin
      u = ix(upc);
      m2[u] = ut ? ((get2(u) == 3) ? 3 : get2(u) + 1) : ((get2(u) == 0) ? 0 : get2(u) - 1);
      m1[u] = ut;
    end
  endtask

  task automatic upd(string tag, logic [31:0] pc, logic t);
    step(tag, pc, 1'b1, pc, t);
  endtask
  task automatic look(string tag, logic [31:0] pc);
    step(tag, pc, 1'b0, 32'h0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int miss0, miss1;
    logic [31:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    look("R1", 32'h0000_0000);
    look("R1", 32'h0000_3ffc);
    look("R1", 32'h1234_5678);
    upd("R1", 32'h0000_0100, 1'b1);
    look("R1", 32'h0000_0100);
    chk("R1", "one taken flips 2-bit", p0, 1'b1);

    // R3 R4 R5 on one entry
    b = 32'h0000_0200;
    repeat (3) upd("R5", b, 1'b1);
    upd("R5", b, 1'b1);
    look("R5", b);
    chk("R5", "saturated taken", p0, 1'b1);
    upd("R4", b, 1'b0);
    look("R4", b);
    chk("R4", "one miss keeps taken", p0, 1'b1);
    chk("R6", "1-bit inverted", p1, 1'b0);
    upd("R4", b, 1'b0);
    look("R4", b);
    chk("R4", "second miss flips", p0, 1'b0);
    repeat (3) upd("R5", b, 1'b0);
    upd("R3", b, 1'b1);
    look("R3", b);
    chk("R3", "from 00 one taken stays not taken", p0, 1'b0);
    chk("R6", "1-bit last outcome", p1, 1'b1);

    // R2 aliasing
    b = 32'h0000_0400;
    upd("R2", b, 1'b1);
    upd("R2", b | 32'h3, 1'b1);
    look("R2", b + (32'h1 << (IDXB + 2)));
    chk("R2", "alias above index", p0, 1'b1);
    look("R2", b | 32'h2);
    chk("R2", "alias low bits", p0, 1'b1);
    look("R2", b + 32'h4);
    chk("R2", "neighbour untouched", p0, 1'b0);

    // R7 same-cycle lookup sees old value
    b = 32'h0000_0800;
    step("R7", b, 1'b1, b, 1'b1);
    chk("R7", "pre-update value", p0, 1'b0);
    chk("R7", "pre-update value 1-bit", p1, 1'b0);
    look("R7", b);
    chk("R7", "next cycle new value", p0, 1'b1);

    // R8 disabled update
    b = 32'h0000_0a00;
    repeat (4) step("R8", b, 1'b0, b, 1'b1);
    chk("R8", "no change 2-bit", p0, 1'b0);
    chk("R8", "no change 1-bit", p1, 1'b0);

    // R9 loop branch
    b = 32'h0000_0c00;
    for (int pass = 0; pass < 3; pass++) begin
      miss0 = 0; miss1 = 0;
      for (int it = 0; it < 10; it++) begin
        step("R9", b, 1'b1, b, it < 9);
        if (p0 != (it < 9)) miss0++;
        if (p1 != (it < 9)) miss1++;
      end
      if (pass > 0) begin
        chk("R9", "2-bit one miss per pass", miss0 == 1, 1'b1);
        chk("R9", "1-bit two misses per pass", miss1 == 2, 1'b1);
      end
    end

    // R3 mixed traffic with aliasing
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] a, c;
      a = {$urandom_range(3, 0), 18'h0, 4'($urandom_range(15, 0)), 6'h0, 2'($urandom)};
      c = {$urandom_range(3, 0), 18'h0, 4'($urandom_range(15, 0)), 6'h0, 2'($urandom)};
      if (($urandom % 4) == 0) c = a;
      step("R3", a, 1'($urandom), c, 1'($urandom));
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule